// File: doc/BRIEF.md
# Interrupt Exception Entry and Return Sequencer

This block sits on the CPU side of the interrupt path. An interrupt request that the interrupt controller has already accepted is taken only at an instruction boundary, and only while the status register does not block further interrupts. When the request is taken, the block captures the source's event code. It saves the current status register, program counter and stack-pointer register (R15) into shadow registers. It then issues a single registered update: a new status word with the block, privileged-mode and register-bank bits forced to 1, and a fetch redirect to the vector base plus 0x600.

The same block runs the return-from-exception path. A return strobe loads the saved status word back as the new status register and redirects the fetch to the saved program counter. The surrounding core writes `sr_new` into its status register and restarts fetch at `redir_pc` in every cycle in which `redir_vld` is high. Instruction decode stays outside the block. The core supplies the boundary and return strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: An interrupt is taken at a rising clock edge only if all of the following hold at that edge: `insn_brk`=1, `irq_req`=1, SR bit 28 (block bit) = 0, `rte_req`=0, and `redir_vld`=0. In the cycle that follows, `irq_ack` and `redir_vld` are both 1 for exactly one cycle.
- R2: On entry, `evt_code` takes the `irq_code` value present at the taking edge.
- R3: On entry, `saved_sr` takes `cur_sr` and `saved_pc` takes `cur_pc`.
- R4: On entry, `saved_r15` takes `cur_r15`.
- R5: On entry, `sr_new` equals `cur_sr` with bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) set to 1.
- R6: On entry, the interrupt mask field SR[7:4] and every bit other than 28 to 30 pass into `sr_new` unchanged.
- R7: On entry, `redir_pc` equals `vbr` + 0x600, computed modulo 2^32.
- R8: While SR bit 28 is 1, a request at a boundary produces no `irq_ack` and leaves every saved register unchanged. The request is taken at the first boundary after bit 28 returns to 0.
- R9: A cycle with `rte_req`=1 causes, one cycle later, `redir_vld`=1, `irq_ack`=0, `sr_new`=`saved_sr` and `redir_pc`=`saved_pc`. The saved registers are left unchanged.
- R10: When `rte_req` and a takeable interrupt occur at the same edge, the return wins and the interrupt waits. Strobes that arrive while `redir_vld` is 1 are ignored, so `redir_vld` is never high in two consecutive cycles.
- R11: While `rst` is 1, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Accepted interrupt request from the controller (level) |
| irq_code | input | 12 | Event code of the requesting source |
| insn_brk | input | 1 | Instruction-boundary strobe |
| rte_req | input | 1 | Return-from-exception strobe |
| cur_sr | input | 32 | Current status register |
| cur_pc | input | 32 | Current program counter |
| cur_r15 | input | 32 | Current R15 (stack pointer) |
| vbr | input | 32 | Vector base register |
| irq_ack | output | 1 | One-cycle acknowledge of a taken interrupt |
| redir_vld | output | 1 | One-cycle strobe: load `sr_new` and fetch from `redir_pc` |
| redir_pc | output | 32 | New fetch address |
| sr_new | output | 32 | New status register value |
| evt_code | output | 12 | Interrupt event register |
| saved_sr | output | 32 | Saved status register |
| saved_pc | output | 32 | Saved program counter |
| saved_r15 | output | 32 | Saved R15 |

## Verification
Every result is due exactly one clock after the edge that samples the strobe, because each output passes through a single register. The bench drives its inputs on the falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. One further falling edge then confirms that the acknowledge and redirect pulses have dropped. In the blocked case and the in-flight case, the bench keeps the strobes high across several edges. It checks each sampled cycle for the missing acknowledge and then checks that the request is taken one cycle after the blocking condition clears.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TAKE = 2'd1,
    ACT_RTE  = 2'd2
  } act_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
(
  input  logic irq_req,
  input  logic insn_brk,
  input  logic rte_req,
  input  logic blocked,
  input  logic busy,
  output act_e act
);
  always_comb begin
    act = ACT_NONE;
    if (!busy) begin
      if (rte_req)
        act = ACT_RTE;
      else if (insn_brk && irq_req && !blocked)
        act = ACT_TAKE;
    end
  end
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter int XLEN = 32,
  parameter int EVW  = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [EVW-1:0]  code_in,
  input  logic [XLEN-1:0] sr_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] r15_in,
  output logic [EVW-1:0]  evt_q,
  output logic [XLEN-1:0] ssr_q,
  output logic [XLEN-1:0] spc_q,
  output logic [XLEN-1:0] sgr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
      ssr_q <= '0;
      spc_q <= '0;
      sgr_q <= '0;
    end else if (take) begin
      evt_q <= code_in;
      ssr_q <= sr_in;
      spc_q <= pc_in;
      sgr_q <= r15_in;
    end
  end
endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_entry_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              BL_BIT  = 28,
  parameter int              RB_BIT  = 29,
  parameter int              MD_BIT  = 30,
  parameter logic [XLEN-1:0] VEC_OFS = 32'h0000_0600
) (
  input  logic            clk,
  input  logic            rst,
  input  act_e            act,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] vbr,
  input  logic [XLEN-1:0] ssr,
  input  logic [XLEN-1:0] spc,
  output logic            ack_q,
  output logic            vld_q,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] sr_q
);
  localparam logic [XLEN-1:0] ONE      = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] SET_MASK = (ONE << BL_BIT) | (ONE << RB_BIT) | (ONE << MD_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      pc_q  <= '0;
      sr_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      vld_q <= 1'b0;
      case (act)
        ACT_TAKE: begin
          ack_q <= 1'b1;
          vld_q <= 1'b1;
          pc_q  <= vbr + VEC_OFS;
          sr_q  <= cur_sr | SET_MASK;
        end
        ACT_RTE: begin
          vld_q <= 1'b1;
          pc_q  <= spc;
          sr_q  <= ssr;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              EVW     = 12,
  parameter int              BL_BIT  = 28,
  parameter int              RB_BIT  = 29,
  parameter int              MD_BIT  = 30,
  parameter logic [XLEN-1:0] VEC_OFS = 32'h0000_0600
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq_req,
  input  logic [EVW-1:0]  irq_code,
  input  logic            insn_brk,
  input  logic            rte_req,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_r15,
  input  logic [XLEN-1:0] vbr,
  output logic            irq_ack,
  output logic            redir_vld,
  output logic [XLEN-1:0] redir_pc,
  output logic [XLEN-1:0] sr_new,
  output logic [EVW-1:0]  evt_code,
  output logic [XLEN-1:0] saved_sr,
  output logic [XLEN-1:0] saved_pc,
  output logic [XLEN-1:0] saved_r15
);
  act_e act;

  irq_arbiter u_arb (
    .irq_req  (irq_req),
    .insn_brk (insn_brk),
    .rte_req  (rte_req),
    .blocked  (cur_sr[BL_BIT]),
    .busy     (redir_vld),
    .act      (act)
  );

  irq_shadow #(.XLEN(XLEN), .EVW(EVW)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .take    (act == ACT_TAKE),
    .code_in (irq_code),
    .sr_in   (cur_sr),
    .pc_in   (cur_pc),
    .r15_in  (cur_r15),
    .evt_q   (evt_code),
    .ssr_q   (saved_sr),
    .spc_q   (saved_pc),
    .sgr_q   (saved_r15)
  );

  irq_redirect #(
    .XLEN(XLEN), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT), .VEC_OFS(VEC_OFS)
  ) u_redir (
    .clk    (clk),
    .rst    (rst),
    .act    (act),
    .cur_sr (cur_sr),
    .vbr    (vbr),
    .ssr    (saved_sr),
    .spc    (saved_pc),
    .ack_q  (irq_ack),
    .vld_q  (redir_vld),
    .pc_q   (redir_pc),
    .sr_q   (sr_new)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int              XLEN    = 32,
  parameter int              EVW     = 12,
  parameter int              BL_BIT  = 28,
  parameter int              RB_BIT  = 29,
  parameter int              MD_BIT  = 30,
  parameter logic [XLEN-1:0] VEC_OFS = 32'h0000_0600
) (
  input logic            clk,
  input logic            rst,
  input logic            irq_req,
  input logic [EVW-1:0]  irq_code,
  input logic            insn_brk,
  input logic            rte_req,
  input logic [XLEN-1:0] cur_sr,
  input logic [XLEN-1:0] cur_pc,
  input logic [XLEN-1:0] cur_r15,
  input logic [XLEN-1:0] vbr,
  input logic            irq_ack,
  input logic            redir_vld,
  input logic [XLEN-1:0] redir_pc,
  input logic [XLEN-1:0] sr_new,
  input logic [EVW-1:0]  evt_code,
  input logic [XLEN-1:0] saved_sr,
  input logic [XLEN-1:0] saved_pc,
  input logic [XLEN-1:0] saved_r15
);
  // R1: an acknowledge follows a boundary with a request
  p_boundary_only_r1: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> ($past(insn_brk) && $past(irq_req)));

  // R2
  p_code_latched_r2: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (evt_code == $past(irq_code)));

  // R3
  p_sr_pc_saved_r3: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (saved_sr == $past(cur_sr) && saved_pc == $past(cur_pc)));

  // R4
  p_r15_saved_r4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (saved_r15 == $past(cur_r15)));

  // R5
  p_ctrl_bits_set_r5: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (sr_new[BL_BIT] && sr_new[RB_BIT] && sr_new[MD_BIT]));

  // R6
  p_mask_kept_r6: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (sr_new[7:4] == $past(cur_sr[7:4])));

  // R7
  p_vector_r7: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (redir_pc == $past(vbr) + VEC_OFS));

  // R8
  p_block_gates_r8: assert property (@(posedge clk) disable iff (rst)
    (insn_brk && cur_sr[BL_BIT]) |=> !irq_ack);

  // R9
  p_return_r9: assert property (@(posedge clk) disable iff (rst)
    (rte_req && !redir_vld) |=> (redir_vld && !irq_ack &&
      sr_new == $past(saved_sr) && redir_pc == $past(saved_pc) && $stable(saved_sr)));

  // R10
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    redir_vld |=> !redir_vld);

  // R1: acknowledge implies redirect
  p_ack_redirect_r1: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> redir_vld);

  // R11
  always_ff @(posedge clk) begin
    if ($past(rst) && rst)
      a_reset_r11: assert (!irq_ack && !redir_vld && redir_pc == '0 && saved_sr == '0);
  end
endmodule

bind irq_entry_seq irq_entry_chk #(
  .XLEN(XLEN), .EVW(EVW), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT), .VEC_OFS(VEC_OFS)
) u_chk (.*);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        irq_req, insn_brk, rte_req;
  logic [11:0] irq_code;
  logic [31:0] cur_sr, cur_pc, cur_r15, vbr;
  logic        irq_ack, redir_vld;
  logic [31:0] redir_pc, sr_new, saved_sr, saved_pc, saved_r15;
  logic [11:0] evt_code;

  int nchk = 0;
  int nfail = 0;

  logic [31:0] e_ssr = '0, e_spc = '0, e_sgr = '0;
  logic [11:0] e_evt = '0;

  localparam logic [31:0] BLM = 32'h1000_0000;
  localparam logic [31:0] SETM = 32'h7000_0000;

  always #2 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_code(irq_code), .insn_brk(insn_brk),
    .rte_req(rte_req), .cur_sr(cur_sr), .cur_pc(cur_pc), .cur_r15(cur_r15), .vbr(vbr),
    .irq_ack(irq_ack), .redir_vld(redir_vld), .redir_pc(redir_pc), .sr_new(sr_new),
    .evt_code(evt_code), .saved_sr(saved_sr), .saved_pc(saved_pc), .saved_r15(saved_r15)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_saved(input string tag);
    chk({tag, " evt"}, 64'(evt_code), 64'(e_evt));
    chk({tag, " ssr"}, 64'(saved_sr), 64'(e_ssr));
    chk({tag, " spc"}, 64'(saved_pc), 64'(e_spc));
    chk({tag, " sgr"}, 64'(saved_r15), 64'(e_sgr));
  endtask

  task automatic chk_entry(input string tag);
    chk({tag, " R1 ack"}, 64'(irq_ack), 64'd1);
    chk({tag, " R1 vld"}, 64'(redir_vld), 64'd1);
    chk({tag, " R5 R6 sr_new"}, 64'(sr_new), 64'(cur_sr | SETM));
    chk({tag, " R7 redir_pc"}, 64'(redir_pc), 64'(vbr + 32'h600));
    e_evt = irq_code; e_ssr = cur_sr; e_spc = cur_pc; e_sgr = cur_r15;
    chk_saved({tag, " R2 R3 R4"});
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; irq_req = 0; insn_brk = 0; rte_req = 0; irq_code = '0;
    cur_sr = '0; cur_pc = '0; cur_r15 = '0; vbr = '0;
    irq_req = 1; insn_brk = 1; rte_req = 1; vbr = 32'hFFFF_FFFF;
    repeat (3) step();
    chk("R11 reset ack", 64'(irq_ack), 64'd0);
    chk("R11 reset vld", 64'(redir_vld), 64'd0);
    chk("R11 reset pc", 64'(redir_pc), 64'd0);
    chk("R11 reset sr", 64'(sr_new), 64'd0);
    chk_saved("R11 reset");
    irq_req = 0; insn_brk = 0; rte_req = 0; vbr = '0;
    rst = 1'b0;
    step();

    // R1..R8 sweep: half with block bit clear, half with it set
    for (int i = 0; i < 64; i++) begin
      logic [31:0] s;
      s = 32'(i) * 32'h0123_4567 ^ 32'h8000_00F1;
      if (i[0]) s = s | BLM; else s = s & ~BLM;
      cur_sr   = s;
      cur_pc   = 32'h8C00_0000 + 32'(i) * 32'h40;
      cur_r15  = ~cur_pc;
      vbr      = 32'hFFFF_F000 + 32'(i) * 32'h0010_0100;
      irq_code = 12'(i * 13 + 5);
      irq_req  = 1; insn_brk = 1;
      step();
      insn_brk = 0;
      if (!i[0]) begin
        chk_entry("sweep");
      end else begin
        chk("sweep R8 blocked ack", 64'(irq_ack), 64'd0);
        chk_saved("sweep R8 blocked saved");
      end
      irq_req = 0;
      step();
      chk("sweep R1 pulse ack", 64'(irq_ack), 64'd0);
      chk("sweep R10 pulse vld", 64'(redir_vld), 64'd0);
    end

    // R8: pending while blocked, taken once the bit clears
    cur_sr = 32'h1000_0030; irq_req = 1; insn_brk = 1; irq_code = 12'h3A0;
    cur_pc = 32'h0000_1234; cur_r15 = 32'h0C00_FF00; vbr = 32'h8000_0000;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 pending no ack", 64'(irq_ack), 64'd0);
    end
    cur_sr = 32'h0000_0030;
    step();
    chk_entry("R8 release");
    insn_brk = 0; irq_req = 0;
    step();

    // R9: return restores saved state and leaves shadows alone
    cur_sr = 32'h7000_0030; cur_pc = 32'h0000_0777;
    rte_req = 1;
    step();
    rte_req = 0;
    chk("R9 rte vld", 64'(redir_vld), 64'd1);
    chk("R9 rte ack", 64'(irq_ack), 64'd0);
    chk("R9 rte sr", 64'(sr_new), 64'(e_ssr));
    chk("R9 rte pc", 64'(redir_pc), 64'(e_spc));
    chk_saved("R9 rte shadows");
    step();

    // R10: return wins over a takeable interrupt at the same edge
    cur_sr = 32'h0000_00F0; cur_pc = 32'h0000_4000; cur_r15 = 32'h1111_2222;
    vbr = 32'h0000_1000; irq_code = 12'h5C0;
    irq_req = 1; insn_brk = 1; rte_req = 1;
    step();
    rte_req = 0;
    chk("R10 rte wins vld", 64'(redir_vld), 64'd1);
    chk("R10 rte wins ack", 64'(irq_ack), 64'd0);
    chk("R10 rte wins pc", 64'(redir_pc), 64'(e_spc));
    chk_saved("R10 rte wins shadows");
    // still high during redirect cycle: ignored
    step();
    chk("R10 busy ignore ack", 64'(irq_ack), 64'd0);
    chk("R10 busy ignore vld", 64'(redir_vld), 64'd0);
    step();
    chk_entry("R10 taken after");
    // inputs unchanged in its redirect cycle: ignored
    step();
    chk("R10 in-flight ack", 64'(irq_ack), 64'd0);
    chk("R10 in-flight vld", 64'(redir_vld), 64'd0);
    insn_brk = 0; irq_req = 0;
    step();

    // R1: request without boundary is not taken
    irq_req = 1; cur_sr = '0;
    repeat (2) step();
    chk("R1 no boundary ack", 64'(irq_ack), 64'd0);
    irq_req = 0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule